// File: doc/BRIEF.md
# Coarse Count Skew Correction Logic

This block sits beside the coarse counter of a two-step time-to-digital converter. The coarse stage counts reference clock cycles while a coarse enable is high. A separate fine stage starts on a fine-start marker and resolves the residue. Path skew between the coarse enable and the fine-start marker can leave the coarse count off by one in either direction. The block detects that case and returns a corrected count.

The block holds the coarse counter itself. The counter is clocked on the falling edge of the clock ANDed with the coarse enable. When the enable drops while the clock is high, that drop produces one extra count. Two capture flops record how the conversion ended:
- A dual-edge flop samples the enable on every change of counter bit 0. It records whether the last count came from a clock edge or from the enable edge.
- A falling-edge flop samples the fine-start marker when the enable falls.

The MSB of the fine code is 1 when the marker rose in the high half of the clock period. It selects whether a subtract-one or an add-one correction is possible. A conversion-start pulse clears the counter and both capture flops.

Top module: `coarse_skew_fix`

## Requirements
- R1: After reset, and after a pulse on conv_start_i, raw_cnt_o is 0 and neither add_one_o nor sub_one_o is high.
- R2: raw_cnt_o counts the falling clock edges seen while coarse_en_i is high. It counts one more when coarse_en_i falls while clk_i is high.
- R3: sub_one_o is high when all three of these hold:
  - fine_msb_i is 0.
  - The last count change came from coarse_en_i falling, not from a clock edge.
  - fine_start_i was already high when coarse_en_i fell.

  In that case cnt_o is raw_cnt_o minus 1.
- R4: add_one_o is high when all three of these hold:
  - fine_msb_i is 1.
  - The last count change came from a falling clock edge while coarse_en_i was high.
  - fine_start_i was still low when coarse_en_i fell.

  In that case cnt_o is raw_cnt_o plus 1.
- R5: In every other combination, both flags are low and cnt_o equals raw_cnt_o.
- R6: add_one_o and sub_one_o are never high together.
- R7: A subtract-one correction on a raw count of 0 gives cnt_o = 0.
- R8: An add-one correction on a raw count of all ones gives cnt_o = all ones.
- R9: conv_start_i clears both capture flops to the no-correction state. Right after a start pulse with no enable activity, neither flag rises for fine_msb_i = 0 or 1.
- R10: Marker skew anywhere in the open range minus one to plus one clock period, on either side of the enable fall, yields the R3/R4/R5 outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Conversion start pulse; clears the counter and the capture flops |
| coarse_en_i | input | 1 | Coarse enable, high across the measured interval |
| fine_start_i | input | 1 | Fine-start marker, rises at the end of the interval |
| fine_msb_i | input | 1 | MSB of the fine code (1 = marker rose in the high clock half) |
| raw_cnt_o | output | CNT_W | Uncorrected coarse count |
| add_one_o | output | 1 | Add-one correction flag |
| sub_one_o | output | 1 | Subtract-one correction flag |
| cnt_o | output | CNT_W | Corrected coarse count |

## Verification
The enable fall is placed in the low or the high clock half. This separates an ordinary end of count from the extra count made by the enable edge. The marker is placed before or after the enable fall, at skews from small to close to a full period. The fine MSB is taken from the clock level at the marker edge. Together these separate the subtract-one case, the add-one case and the neutral combinations. A zero-length interval and an interval of all-ones counts exercise the clamp and the saturation. A bare start pulse after an add-one case shows that stale captured state is cleared.

// File: rtl/coarse_skew_pkg.sv
`timescale 1ns/1ps
package coarse_skew_pkg;
  typedef struct packed {
    logic add;
    logic sub;
  } corr_t;

  localparam corr_t CORR_NONE = '{add: 1'b0, sub: 1'b0};
endpackage

// File: rtl/skew_gate_cnt.sv
`timescale 1ns/1ps
module skew_gate_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic gclk;
  logic [CNT_W-1:0] cnt_q;

  // falling edge of clk AND enable: counts clock falls and a late enable drop
  assign gclk = clk_i & en_i;

  always_ff @(negedge gclk or negedge clr_ni) begin
    if (!clr_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/skew_edge_capture.sv
`timescale 1ns/1ps
module skew_edge_capture (
  input  logic clr_ni,
  input  logic en_i,
  input  logic lsb_i,
  input  logic mark_i,
  output logic q_o,
  output logic p_o
);
  logic q_q;
  logic mark_q;

  // enable level at every count change: 1 = last count came from clk
  always_ff @(posedge lsb_i or negedge lsb_i or negedge clr_ni) begin
    if (!clr_ni) q_q <= 1'b0;
    else         q_q <= en_i;
  end

  // marker level when enable drops
  always_ff @(negedge en_i or negedge clr_ni) begin
    if (!clr_ni) mark_q <= 1'b0;
    else         mark_q <= mark_i;
  end

  assign q_o = q_q;
  assign p_o = ~mark_q;
endmodule

// File: rtl/skew_corr_decide.sv
`timescale 1ns/1ps
module skew_corr_decide
  import coarse_skew_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             q_i,
  input  logic             p_i,
  input  logic             msb_i,
  input  logic [CNT_W-1:0] raw_i,
  output corr_t            corr_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_comb begin
    corr_o     = CORR_NONE;
    corr_o.sub = ~(msb_i | q_i | p_i);
    corr_o.add = msb_i & q_i & p_i;
  end

  always_comb begin
    cnt_o = raw_i;
    if (corr_o.sub && raw_i != '0)           cnt_o = raw_i - CNT_W'(1);
    else if (corr_o.add && raw_i != CNT_MAX) cnt_o = raw_i + CNT_W'(1);
  end
endmodule

// File: rtl/coarse_skew_fix.sv
`timescale 1ns/1ps
module coarse_skew_fix
  import coarse_skew_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_start_i,
  input  logic             coarse_en_i,
  input  logic             fine_start_i,
  input  logic             fine_msb_i,
  output logic [CNT_W-1:0] raw_cnt_o,
  output logic             add_one_o,
  output logic             sub_one_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             clr_n;
  logic [CNT_W-1:0] raw;
  logic             q, p;
  corr_t            corr;

  assign clr_n = rst_ni & ~conv_start_i;

  skew_gate_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .clr_ni(clr_n),
    .en_i  (coarse_en_i),
    .cnt_o (raw)
  );

  skew_edge_capture u_cap (
    .clr_ni(clr_n),
    .en_i  (coarse_en_i),
    .lsb_i (raw[0]),
    .mark_i(fine_start_i),
    .q_o   (q),
    .p_o   (p)
  );

  skew_corr_decide #(.CNT_W(CNT_W)) u_dec (
    .q_i   (q),
    .p_i   (p),
    .msb_i (fine_msb_i),
    .raw_i (raw),
    .corr_o(corr),
    .cnt_o (cnt_o)
  );

  assign raw_cnt_o = raw;
  assign add_one_o = corr.add;
  assign sub_one_o = corr.sub;
endmodule

// File: rtl/coarse_skew_fix_chk.sv
`timescale 1ns/1ps
module coarse_skew_fix_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fine_msb_i,
  input logic [CNT_W-1:0] raw_cnt_o,
  input logic             add_one_o,
  input logic             sub_one_o,
  input logic [CNT_W-1:0] cnt_o
);
  // R6
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(add_one_o && sub_one_o));

  // R3
  sub_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_one_o |-> (!fine_msb_i && (raw_cnt_o == '0 ? cnt_o == '0 : cnt_o == raw_cnt_o - CNT_W'(1))));

  // R4
  add_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_one_o |-> (fine_msb_i && (raw_cnt_o == '1 ? cnt_o == '1 : cnt_o == raw_cnt_o + CNT_W'(1))));

  // R5
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_one_o && !sub_one_o) |-> cnt_o == raw_cnt_o);

  // R7
  zero_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_cnt_o == '0) |-> cnt_o != '1);
endmodule

bind coarse_skew_fix coarse_skew_fix_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fine_msb_i(fine_msb_i),
  .raw_cnt_o (raw_cnt_o),
  .add_one_o (add_one_o),
  .sub_one_o (sub_one_o),
  .cnt_o     (cnt_o)
);

// File: tb/coarse_skew_fix_bench.sv
`timescale 1ns/1ps
module coarse_skew_fix_bench;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, en = 1'b0, st1 = 1'b0, msb = 1'b0;
  logic [CNT_W-1:0] raw, cnt;
  logic add, sub;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  coarse_skew_fix #(.CNT_W(CNT_W)) u_coarse_skew_fix (
    .clk_i(clk), .rst_ni(rst_n), .conv_start_i(start), .coarse_en_i(en),
    .fine_start_i(st1), .fine_msb_i(msb), .raw_cnt_o(raw),
    .add_one_o(add), .sub_one_o(sub), .cnt_o(cnt)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    #1.0 start = 1'b1; st1 = 1'b0; msb = 1'b0;
    #0.5 start = 1'b0;
    #0.5;
  endtask

  // n full cycles, enable drop at phase ph (0..5, clk high above 2.5), marker at drop+skew
  task automatic conv(string tag, int n, real ph, real skew);
    int  raw_e, cnt_e, q_e, p_e, msb_e, add_e, sub_e;
    real tf, sp;
    pulse_start();
    en = 1'b1;
    tf = 5.0 * n + ph;
    if (skew < 0.0) begin
      #(tf - 2.0 + skew) st1 = 1'b1;
      #(-skew) en = 1'b0;
    end else begin
      #(tf - 2.0) en = 1'b0;
      #(skew) st1 = 1'b1;
    end
    sp = ph + skew;
    while (sp < 0.0)  sp += 5.0;
    while (sp >= 5.0) sp -= 5.0;
    msb_e = (sp > 2.5) ? 1 : 0;
    msb   = msb_e[0];
    #1.0;
    raw_e = (n + ((ph > 2.5) ? 1 : 0)) % (1 << CNT_W);
    q_e   = (raw_e > 0 && ph < 2.5) ? 1 : 0;
    p_e   = (skew < 0.0) ? 0 : 1;
    sub_e = (msb_e == 0 && q_e == 0 && p_e == 0) ? 1 : 0;
    add_e = (msb_e == 1 && q_e == 1 && p_e == 1) ? 1 : 0;
    cnt_e = raw_e;
    if (sub_e == 1 && raw_e > 0) cnt_e = raw_e - 1;
    if (add_e == 1 && raw_e < (1 << CNT_W) - 1) cnt_e = raw_e + 1;
    check({"R2 raw ", tag}, int'(raw), raw_e);
    check({"R3 sub ", tag}, int'(sub), sub_e);
    check({"R4 add ", tag}, int'(add), add_e);
    check({"R5 cnt ", tag}, int'(cnt), cnt_e);
    check({"R6 excl ", tag}, int'(add & sub), 0);
  endtask

  task automatic t_reset();
    check("R1 reset raw", int'(raw), 0);
    check("R1 reset add", int'(add), 0);
    check("R1 reset sub", int'(sub), 0);
  endtask

  task automatic t_plain();
    conv("R5 low-drop late-mark", 5, 1.0, 1.0);
    conv("R5 high-drop early-mark", 7, 3.5, -0.7);
  endtask

  task automatic t_sub();
    conv("R3 sub", 6, 4.0, -2.0);
    conv("R3 sub wide", 3, 4.9, -2.5);
  endtask

  task automatic t_add();
    conv("R4 add", 9, 1.0, 2.0);
    conv("R4 add wide", 3, 0.2, 2.4);
  endtask

  task automatic t_clear();
    conv("R9 pre add", 2, 1.0, 2.0);
    pulse_start();
    msb = 1'b1;
    #0.5;
    check("R9 clear add msb1", int'(add), 0);
    check("R9 clear sub msb1", int'(sub), 0);
    check("R1 start raw", int'(raw), 0);
    msb = 1'b0;
    #0.5;
    check("R9 clear sub msb0", int'(sub), 0);
    check("R9 clear add msb0", int'(add), 0);
  endtask

  task automatic t_clamp();
    conv("R7 clamp", 0, 2.3, -0.2);
    check("R7 clamp cnt", int'(cnt), 0);
  endtask

  task automatic t_sat();
    conv("R8 sat", 255, 1.0, 2.0);
    check("R8 sat cnt", int'(cnt), 255);
  endtask

  task automatic t_skew();
    conv("R10 neg edge of range", 4, 4.0, -4.5);
    conv("R10 pos edge of range", 4, 1.0, 4.5);
    conv("R10 small neg", 3, 4.0, -0.3);
    conv("R10 small pos", 5, 3.0, 0.3);
  endtask

  initial begin
    #12.2 rst_n = 1'b1;
    #1.0;
    t_reset();
    t_plain();
    t_sub();
    t_add();
    t_clear();
    t_clamp();
    t_sat();
    t_skew();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule